// File: doc/BRIEF.md
# Paged Convolution Coefficient Store

This block keeps the kernel weights and the configuration of an image convolution engine. It holds four pages of nine signed 8-bit weights, plus three 8-bit configuration registers (operating mode, rounding precision and data format). While the active-low load enable is low, each clock edge can write one byte. The byte comes from the data control port. The target is given by the address control port, which carries a page number and an index. Index values beyond the last weight select the configuration registers.

A 2-bit page select picks which stored page drives the nine weight outputs. The read path is purely combinational, so a write becomes visible in the cycle after its clock edge. The block also tracks the three-clock data cycle of the engine. The slot counter restarts on the edge where the load enable returns high. In the five-by-five mode the two control ports carry samples in slot 0, so writes are refused in that slot.

Top module: `coef_page_store`

## Requirements
- R1: After reset every weight of every page is zero, all three configuration registers are zero, and the slot output is 0.
- R2: On a rising edge with `load_n` low and a permitted slot, and with `ctl_addr[3:0]` in the range 0..8, the weight at page `ctl_addr[5:4]` and index `ctl_addr[3:0]` takes the value of `ctl_data`. The new value is visible from the next cycle.
- R3: While `load_n` is high, no weight and no configuration register changes.
- R4: Index 9 writes `cfg_mode`, index 10 writes `cfg_round` and index 11 writes `cfg_format`. Indices 12..15 change nothing.
- R5: `coef_o[8k+7:8k]` equals weight k of the page chosen by `page_sel`, and follows `page_sel` in the same cycle.
- R6: `data_slot` is 0 on the first edge where `load_n` is high after being low. It then steps 1, 2, 0, 1, ... on every edge, whatever `load_n` does, and never shows 3.
- R7: When `cfg_mode[0]` is 1 (five-by-five mode), a write attempted while `data_slot` is 0 has no effect. In slots 1 and 2 writes proceed.
- R8: Bits 7:6 of `ctl_addr` have no effect on which location is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_n | input | 1 | Active-low write enable for weights and configuration |
| ctl_addr | input | 8 | Page in bits 5:4, index in bits 3:0 |
| ctl_data | input | 8 | Byte to be written |
| page_sel | input | 2 | Page driven onto the weight outputs |
| coef_o | output | 72 | Nine weights of the selected page, weight k in bits 8k+7:8k |
| cfg_mode | output | 8 | Mode register; bit 0 selects five-by-five operation |
| cfg_round | output | 8 | Rounding precision register |
| cfg_format | output | 8 | Data format register |
| data_slot | output | 2 | Position within the three-clock data cycle |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a write and a read of the same page. The bench writes into the page that `page_sel` is showing, and expects the old value before the edge and the new value after it. The second pair is a write attempt and slot 0 while five-by-five mode is active. The bench sets bit 0 of the mode register, raises and lowers `load_n` so that the slot restarts, and then aims writes at every slot. A reference model, which tracks the slot and the blocking rule, judges whether each write landed. Long random runs that mix enable toggles with page changes cover both pairs many times.

// File: rtl/cstore_pkg.sv
package cstore_pkg;
    localparam int PAGES = 4;
    localparam int TAPS  = 9;
    localparam int CW    = 8;
    localparam int PW    = $clog2(PAGES);
    localparam int IW    = 4;
    localparam int SW    = 2;

    localparam logic [IW-1:0] IDX_MODE  = 4'd9;
    localparam logic [IW-1:0] IDX_ROUND = 4'd10;
    localparam logic [IW-1:0] IDX_FMT   = 4'd11;

    typedef logic [TAPS-1:0][CW-1:0] page_t;

    typedef struct packed {
        page_t [PAGES-1:0] pages;
        logic  [CW-1:0]    mode;
        logic  [CW-1:0]    rnd;
        logic  [CW-1:0]    fmt;
    } bank_t;

    typedef struct packed {
        logic          prev_load_n;
        logic [SW-1:0] cnt;
    } slot_t;
endpackage

// File: rtl/cstore_slot.sv
module cstore_slot
    import cstore_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_n,
    output logic [SW-1:0] slot_o
);
    slot_t q, d;
    logic  restart;

    always_comb begin
        restart = load_n && !q.prev_load_n;
        slot_o  = restart ? '0 : q.cnt;
        d.prev_load_n = load_n;
        if (slot_o == SW'(2)) d.cnt = '0;
        else                  d.cnt = slot_o + SW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.prev_load_n <= 1'b1;
            q.cnt         <= '0;
        end else begin
            q <= d;
        end
    end

    assert_slot_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_o == SW'(2)) |=> (slot_o == SW'(0)));
    assert_slot_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_o == SW'(1)) |=> (slot_o != SW'(1)));
    assert_slot_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_o != SW'(3)));
endmodule

// File: rtl/cstore_bank.sv
module cstore_bank
    import cstore_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic [7:0]        addr,
    input  logic [CW-1:0]     data,
    input  logic [SW-1:0]     slot,
    output page_t [PAGES-1:0] pages_o,
    output logic [CW-1:0]     mode_o,
    output logic [CW-1:0]     rnd_o,
    output logic [CW-1:0]     fmt_o
);
    bank_t         q, d;
    logic          we;
    logic [PW-1:0] pg;
    logic [IW-1:0] idx;

    assign pg  = addr[IW+PW-1:IW];
    assign idx = addr[IW-1:0];

    always_comb begin
        d  = q;
        we = !load_n && !(q.mode[0] && slot == '0);
        if (we) begin
            for (int p = 0; p < PAGES; p++) begin
                for (int k = 0; k < TAPS; k++) begin
                    if (pg == PW'(p) && idx == IW'(k)) d.pages[p][k] = data;
                end
            end
            if (idx == IDX_MODE)  d.mode = data;
            if (idx == IDX_ROUND) d.rnd  = data;
            if (idx == IDX_FMT)   d.fmt  = data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pages_o = q.pages;
    assign mode_o  = q.mode;
    assign rnd_o   = q.rnd;
    assign fmt_o   = q.fmt;

    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_n |=> $stable(q));
    assert_block_slot0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && q.mode[0] && slot == '0) |=> $stable(q));
    assert_spare_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && idx >= IW'(12)) |=> $stable(q));
endmodule

// File: rtl/cstore_pagemux.sv
module cstore_pagemux
    import cstore_pkg::*;
(
    input  page_t [PAGES-1:0]  pages,
    input  logic [PW-1:0]      sel,
    output logic [TAPS*CW-1:0] coef_o
);
    page_t chosen;
    assign chosen = pages[sel];

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        assign coef_o[k*CW +: CW] = chosen[k];
    end
endmodule

// File: rtl/coef_page_store.sv
module coef_page_store
    import cstore_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic [7:0]        ctl_addr,
    input  logic [CW-1:0]     ctl_data,
    input  logic [PW-1:0]     page_sel,
    output logic [TAPS*CW-1:0] coef_o,
    output logic [CW-1:0]     cfg_mode,
    output logic [CW-1:0]     cfg_round,
    output logic [CW-1:0]     cfg_format,
    output logic [SW-1:0]     data_slot
);
    page_t [PAGES-1:0] pages;

    cstore_slot u_slot (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .slot_o(data_slot)
    );

    cstore_bank u_bank (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .addr(ctl_addr),
        .data(ctl_data), .slot(data_slot), .pages_o(pages),
        .mode_o(cfg_mode), .rnd_o(cfg_round), .fmt_o(cfg_format)
    );

    cstore_pagemux u_mux (
        .pages(pages), .sel(page_sel), .coef_o(coef_o)
    );
endmodule

// File: tb/coef_page_store_bench.sv
module coef_page_store_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_n = 1'b1;
    logic [7:0]  ctl_addr = '0;
    logic [7:0]  ctl_data = '0;
    logic [1:0]  page_sel = '0;
    logic [71:0] coef_o;
    logic [7:0]  cfg_mode, cfg_round, cfg_format;
    logic [1:0]  data_slot;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [7:0] m_coef [4][9];
    logic [7:0] m_mode, m_rnd, m_fmt;
    logic       m_prev;
    logic [1:0] m_cnt;

    always #2 clk = ~clk;

    coef_page_store u_coef_page_store (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .ctl_addr(ctl_addr),
        .ctl_data(ctl_data), .page_sel(page_sel), .coef_o(coef_o),
        .cfg_mode(cfg_mode), .cfg_round(cfg_round), .cfg_format(cfg_format),
        .data_slot(data_slot)
    );

    function automatic logic [71:0] exp_page(input logic [1:0] p);
        logic [71:0] v;
        for (int k = 0; k < 9; k++) v[k*8 +: 8] = m_coef[p][k];
        return v;
    endfunction

    function automatic logic [1:0] exp_slot(input logic ld);
        return (ld && !m_prev) ? 2'd0 : m_cnt;
    endfunction

    task automatic check(input string tag, input logic [71:0] act, input logic [71:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic ld, input logic [7:0] a, input logic [7:0] dt,
                        input logic [1:0] ps, input string tag);
        logic [1:0] s;
        logic       we;
        @(negedge clk);
        load_n = ld; ctl_addr = a; ctl_data = dt; page_sel = ps;
        #1;
        s = exp_slot(ld);
        check(tag, coef_o, exp_page(ps));
        check("R6 slot", 72'(data_slot), 72'(s));
        check("R4 config", 72'({cfg_mode, cfg_round, cfg_format}), 72'({m_mode, m_rnd, m_fmt}));
        @(posedge clk);
        we = !ld && !(m_mode[0] && s == 2'd0);
        if (we) begin
            if (a[3:0] < 4'd9) m_coef[a[5:4]][a[3:0]] = dt;
            else if (a[3:0] == 4'd9)  m_mode = dt;
            else if (a[3:0] == 4'd10) m_rnd  = dt;
            else if (a[3:0] == 4'd11) m_fmt  = dt;
        end
        m_cnt  = (s == 2'd2) ? 2'd0 : s + 2'd1;
        m_prev = ld;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int p = 0; p < 4; p++) for (int k = 0; k < 9; k++) m_coef[p][k] = '0;
        m_mode = '0; m_rnd = '0; m_fmt = '0; m_prev = 1'b1; m_cnt = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state on every page
        for (int p = 0; p < 4; p++) step(1'b1, 8'h00, 8'h00, 2'(p), "R1 reset");
        // R2: fill every weight, read back page being written
        for (int p = 0; p < 4; p++)
            for (int k = 0; k < 9; k++)
                step(1'b0, {2'b00, 2'(p), 4'(k)}, 8'($urandom), 2'(p), "R2 write");
        for (int p = 0; p < 4; p++) step(1'b0, 8'h0C, 8'h00, 2'(p), "R5 read");
        // R3: enable high, random traffic
        for (int i = 0; i < 40; i++)
            step(1'b1, 8'($urandom) & 8'h38, 8'($urandom), 2'($urandom), "R3 idle");
        // R4: config indices, spare indices
        step(1'b0, 8'h0A, 8'h5A, 2'd0, "R4 cfg");
        step(1'b0, 8'h0B, 8'hC3, 2'd1, "R4 cfg");
        for (int k = 12; k < 16; k++) step(1'b0, 8'(k), 8'hFF, 2'd2, "R4 spare");
        // R8: upper address bits
        for (int i = 0; i < 20; i++)
            step(1'b0, {2'($urandom), 2'($urandom), 4'($urandom % 9)}, 8'($urandom),
                 2'($urandom), "R8 upper");
        // R7: five-by-five mode, slot-0 writes blocked
        step(1'b0, 8'h09, 8'h01, 2'd0, "R7 mode");
        step(1'b1, 8'h00, 8'h00, 2'd0, "R7 idle");
        for (int i = 0; i < 12; i++) step(1'b0, {4'h0, 4'(i % 9)}, 8'(8'h80 + i), 2'd0, "R7 slot");
        for (int r = 0; r < 4; r++) begin
            step(1'b1, 8'h00, 8'h00, 2'd3, "R6 restart");
            for (int i = 0; i < 3; i++) step(1'b0, 8'h33, 8'(r * 3 + i), 2'd3, "R7 slot");
        end
        // leave five-by-five mode, then mixed random
        step(1'b0, 8'h09, 8'h00, 2'd0, "R7 mode");
        step(1'b0, 8'h09, 8'h00, 2'd0, "R7 mode");
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a;
            a = 8'($urandom);
            if (a[3:0] == 4'd9 && ($urandom % 4) != 0) a[3:0] = 4'd2;
            step(($urandom % 3) == 0, a, 8'($urandom), 2'($urandom), "R5 random");
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule